// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial line of a UART transmitter into short infrared pulses for a serial-infrared link. The line is sampled once per bit at a bit boundary. The bit boundary is found by counting a 16x baud tick. A zero (space) bit produces one light pulse. A one (mark) bit stays dark. The optical output `ir_tx_n` is active low, so a pulse is a low level on that pin. Two pulse widths are available. Normal mode gives 3/16 of the bit period, placed in the middle of the bit. Low-power mode gives three periods of a separate reference tick, and that width does not depend on the baud rate.

Encoding runs only when both the UART enable and the SIR enable are set. While encoding runs, the wired transmit line is held at the marking level. While encoding is off, the wired transmit line passes the serial input through unchanged. A receive path stretches each detected pulse into a one-bit-long low level on `rx_ser`. The pulse source is selected by the loopback-test control: with it set, the source is the block's own output pulses; with it clear, the source is the external active-low detector input. The serial line and the pulse lines are level signals with no transfer handshake, so there is no valid/ready interface and no back-pressure. The UART must present each bit for a full bit period.

Top module: `sir_pulse_encoder`

## Requirements
- R1: During reset and just after it, the encoder holds these values: `ir_tx_n` = 1, `rx_ser` = 1, `txd` = `ser_in`.
- R2: Normal mode, zero bit: counting the ticks of a bit period from 0 (tick 0 samples the bit), the tick counter reaches 8 on tick 7. `ir_tx_n` goes low in the clock cycle after tick 7. It returns high in the cycle after tick 10. The pulse lasts exactly three tick periods.
- R3: A one bit produces no pulse in either mode.
- R4: Low-power mode, zero bit: the pulse starts in the cycle after the first `lp_tick` that follows tick 7. It ends in the cycle after the third `lp_tick` after that, giving three `lp_tick` periods whatever the 16x tick rate.
- R5: `lp_mode` (0 = normal, 1 = low-power) is sampled only at a bit boundary, together with the bit. A change in mid-bit applies from the next bit, and a pulse already running always completes.
- R6: While `uart_en` or `sir_en` is 0, these values hold: `ir_tx_n` = 1, `rx_ser` = 1 whatever `ir_rx_n` does, and `txd` = `ser_in`. In particular, `sir_en` has no effect while `uart_en` is 0.
- R7: While `uart_en` and `sir_en` are both 1, `txd` = 1.
- R8: With `loop_test` = 1, the receive path takes the block's own pulses and ignores `ir_rx_n`. With `loop_test` = 0, it takes a low level on `ir_rx_n` as a pulse.
- R9: A rising pulse on the selected receive source drives `rx_ser` low from the next cycle. `rx_ser` stays low for 16 ticks of `tick16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Overall UART enable |
| sir_en | input | 1 | Infrared encoding enable |
| lp_mode | input | 1 | 0 = 3/16-bit pulse, 1 = low-power pulse |
| loop_test | input | 1 | Feed own pulses into the receive path |
| tick16 | input | 1 | One-cycle strobe at 16x the baud rate |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| ser_in | input | 1 | Serial line from the UART transmitter, 1 = mark |
| ir_rx_n | input | 1 | External infrared detector, low = pulse |
| ir_tx_n | output | 1 | Infrared emitter drive, low = pulse |
| txd | output | 1 | Wired transmit line |
| rx_ser | output | 1 | Decoded serial line toward the UART receiver |

## Verification
Each output follows its register state with no further register in between. The pulse edges fall in the cycle after the `tick16` or `lp_tick` strobe that causes them. The `rx_ser` edge falls in the cycle after the source pulse rises. `txd` and the disable gating follow the inputs in the same cycle. The bench drives its inputs at the falling edge and keeps a behavioural model that steps at each rising edge. At each falling edge, before the next stimulus is applied, it compares all three outputs against the model. It also measures complete pulse widths in clock cycles against the widths that the tick rates imply.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;
  typedef enum logic {
    SIR_MODE_NORMAL = 1'b0,
    SIR_MODE_LOWPWR = 1'b1
  } sir_mode_e;
endpackage

// File: rtl/sir_bit_timer.sv
module sir_bit_timer
  import sir_enc_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  localparam int PH_W         = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick16,
  input  logic            ser_in,
  input  sir_mode_e       mode_in,
  output logic [PH_W-1:0] phase,
  output logic            bit_q,
  output sir_mode_e       mode_q,
  output logic            start_evt
);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] START_PH = PH_W'(PULSE_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      bit_q  <= 1'b1;
      mode_q <= SIR_MODE_NORMAL;
    end else if (!active) begin
      phase  <= '0;
      bit_q  <= 1'b1;
      mode_q <= SIR_MODE_NORMAL;
    end else if (tick16) begin
      if (phase == '0) begin
        bit_q  <= ser_in;
        mode_q <= mode_in;
      end
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end
  end

  // Strobe on the tick that marks the centre window of the bit.
  assign start_evt = active && tick16 && (phase == START_PH);
endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen
  import sir_enc_pkg::*;
#(
  parameter int PH_W           = 4,
  parameter int PULSE_START    = 7,
  parameter int PULSE_TICKS    = 3,
  parameter int LP_PULSE_TICKS = 3,
  localparam int LP_W          = $clog2(LP_PULSE_TICKS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            lp_tick,
  input  logic [PH_W-1:0] phase,
  input  logic            bit_q,
  input  sir_mode_e       mode_q,
  input  logic            start_evt,
  output logic            pulse,
  output logic            lp_busy
);
  logic            arm_q;
  logic [LP_W-1:0] lp_cnt;
  logic            normal_on;
  int              ph_i;

  always_comb begin
    ph_i      = int'(phase);
    normal_on = active && !bit_q && (mode_q == SIR_MODE_NORMAL) &&
                (ph_i > PULSE_START) && (ph_i <= PULSE_START + PULSE_TICKS);
  end

  // Low-power pulse: armed at the centre tick, aligned to the next
  // reference tick, then held for a fixed count of reference ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      lp_cnt <= '0;
    end else if (!active) begin
      arm_q  <= 1'b0;
      lp_cnt <= '0;
    end else begin
      if (arm_q && lp_tick) begin
        arm_q  <= 1'b0;
        lp_cnt <= LP_W'(LP_PULSE_TICKS);
      end else if (lp_tick && (lp_cnt != '0)) begin
        lp_cnt <= lp_cnt - 1'b1;
      end
      if (start_evt && !bit_q && (mode_q == SIR_MODE_LOWPWR)) begin
        arm_q <= 1'b1;
      end
    end
  end

  assign lp_busy = (lp_cnt != '0);
  assign pulse   = normal_on || (active && lp_busy);
endmodule

// File: rtl/sir_rx_decode.sv
module sir_rx_decode #(
  parameter int RX_HOLD_TICKS = 16,
  localparam int RX_W         = $clog2(RX_HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick16,
  input  logic pulse_in,
  output logic rx_low
);
  logic            prev_q;
  logic [RX_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      hold_cnt <= '0;
    end else if (!active) begin
      prev_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      prev_q <= pulse_in;
      if (pulse_in && !prev_q) begin
        hold_cnt <= RX_W'(RX_HOLD_TICKS);
      end else if (tick16 && (hold_cnt != '0)) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  assign rx_low = active && (hold_cnt != '0);
endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder
  import sir_enc_pkg::*;
#(
  parameter int TICKS_PER_BIT  = 16,
  parameter int PULSE_START    = 7,
  parameter int PULSE_TICKS    = 3,
  parameter int LP_PULSE_TICKS = 3,
  localparam int PH_W          = $clog2(TICKS_PER_BIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic sir_en,
  input  logic lp_mode,
  input  logic loop_test,
  input  logic tick16,
  input  logic lp_tick,
  input  logic ser_in,
  input  logic ir_rx_n,
  output logic ir_tx_n,
  output logic txd,
  output logic rx_ser
);
  logic            active;
  sir_mode_e       mode_in;
  sir_mode_e       mode_q;
  logic [PH_W-1:0] phase;
  logic            bit_q;
  logic            start_evt;
  logic            pulse;
  logic            lp_busy;
  logic            pulse_in;
  logic            rx_low;

  assign active  = uart_en && sir_en;
  assign mode_in = lp_mode ? SIR_MODE_LOWPWR : SIR_MODE_NORMAL;

  sir_bit_timer #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_START  (PULSE_START)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick16   (tick16),
    .ser_in   (ser_in),
    .mode_in  (mode_in),
    .phase    (phase),
    .bit_q    (bit_q),
    .mode_q   (mode_q),
    .start_evt(start_evt)
  );

  sir_pulse_gen #(
    .PH_W          (PH_W),
    .PULSE_START   (PULSE_START),
    .PULSE_TICKS   (PULSE_TICKS),
    .LP_PULSE_TICKS(LP_PULSE_TICKS)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .lp_tick  (lp_tick),
    .phase    (phase),
    .bit_q    (bit_q),
    .mode_q   (mode_q),
    .start_evt(start_evt),
    .pulse    (pulse),
    .lp_busy  (lp_busy)
  );

  assign pulse_in = loop_test ? pulse : !ir_rx_n;

  sir_rx_decode #(
    .RX_HOLD_TICKS(TICKS_PER_BIT)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .tick16  (tick16),
    .pulse_in(pulse_in),
    .rx_low  (rx_low)
  );

  assign ir_tx_n = !pulse;
  assign txd     = active ? 1'b1 : ser_in;
  assign rx_ser  = !rx_low;
endmodule

// File: rtl/sir_pulse_encoder_chk.sv
module sir_pulse_encoder_chk #(
  parameter int PH_W        = 4,
  parameter int PULSE_START = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            uart_en,
  input logic            sir_en,
  input logic            tick16,
  input logic            ser_in,
  input logic            ir_tx_n,
  input logic            txd,
  input logic            rx_ser,
  input logic [PH_W-1:0] phase,
  input logic            bit_q,
  input logic            mode_q,
  input logic            lp_busy
);
  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(uart_en && sir_en) |-> (ir_tx_n && rx_ser && (txd == ser_in)));

  p_txd_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && sir_en) |-> txd);

  p_one_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && sir_en && bit_q && !lp_busy) |-> ir_tx_n);

  p_mode_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && sir_en && !(tick16 && (phase == '0))) |=> $stable(mode_q));

  p_centre_lit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && sir_en && !bit_q && !mode_q &&
     (phase == PH_W'(PULSE_START + 1))) |-> !ir_tx_n);
endmodule

bind sir_pulse_encoder sir_pulse_encoder_chk #(
  .PH_W       (PH_W),
  .PULSE_START(PULSE_START)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .uart_en(uart_en),
  .sir_en (sir_en),
  .tick16 (tick16),
  .ser_in (ser_in),
  .ir_tx_n(ir_tx_n),
  .txd    (txd),
  .rx_ser (rx_ser),
  .phase  (phase),
  .bit_q  (bit_q),
  .mode_q (mode_q),
  .lp_busy(lp_busy)
);

// File: tb/sir_pulse_encoder_bench.sv
module sir_pulse_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_en = 1'b0, sir_en = 1'b0, lp_mode = 1'b0, loop_test = 1'b0;
  logic tick16 = 1'b0, lp_tick = 1'b0;
  logic ser_in = 1'b1, ir_rx_n = 1'b1;
  logic ir_tx_n, txd, rx_ser;

  int checks = 0, errors = 0;
  int cyc = 0, lp_div = 5;
  int exp_w = 0, low_len = 0;
  string tag_ir = "R1", tag_rx = "R1", tag_w = "R2";
  bit done = 1'b0;

  // behavioural reference state
  int m_ph = 0, m_bit = 1, m_lpq = 0, m_arm = 0, m_lpc = 0, m_rxc = 0, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_pulse_encoder u_sir_pulse_encoder (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en),
    .lp_mode(lp_mode), .loop_test(loop_test), .tick16(tick16),
    .lp_tick(lp_tick), .ser_in(ser_in), .ir_rx_n(ir_rx_n),
    .ir_tx_n(ir_tx_n), .txd(txd), .rx_ser(rx_ser)
  );

  function automatic bit m_active();
    return uart_en && sir_en;
  endfunction

  function automatic bit m_pulse();
    if (!m_active()) return 1'b0;
    if (m_lpc != 0) return 1'b1;
    return (m_lpq == 0) && (m_bit == 0) && (m_ph >= 8) && (m_ph <= 10);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !m_active()) begin
      m_ph = 0; m_bit = 1; m_lpq = 0; m_arm = 0; m_lpc = 0; m_rxc = 0; m_prev = 0;
    end else begin
      bit pin;
      pin = loop_test ? m_pulse() : !ir_rx_n;
      if (pin && !m_prev) m_rxc = 16;
      else if (tick16 && m_rxc > 0) m_rxc--;
      m_prev = pin;
      if (m_arm && lp_tick) begin m_arm = 0; m_lpc = 3; end
      else if (lp_tick && m_lpc > 0) m_lpc--;
      if (tick16) begin
        if (m_ph == 0) begin m_bit = ser_in; m_lpq = lp_mode; end
        if (m_ph == 7 && m_bit == 0 && m_lpq == 1) m_arm = 1;
        m_ph = (m_ph + 1) % 16;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    bit e_ir, e_rx, e_txd;
    @(negedge clk);
    e_ir  = !m_pulse();
    e_txd = m_active() ? 1'b1 : ser_in;
    e_rx  = !(m_active() && m_rxc != 0);
    chk(ir_tx_n == e_ir, tag_ir, "ir_tx_n", ir_tx_n, e_ir);
    chk(txd == e_txd, m_active() ? "R7" : "R6", "txd", txd, e_txd);
    chk(rx_ser == e_rx, tag_rx, "rx_ser", rx_ser, e_rx);
    if (!ir_tx_n) low_len++;
    else begin
      if (low_len > 0 && exp_w > 0)
        chk(low_len == exp_w, tag_w, "pulse width", low_len, exp_w);
      low_len = 0;
    end
    cyc++;
    tick16  = (cyc % TICK_DIV) == 0;
    lp_tick = (cyc % lp_div) == 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_bits(input logic [7:0] pat);
    for (int b = 0; b < 8; b++) begin
      ser_in = pat[b];
      run(16 * TICK_DIV);
    end
    ser_in = 1'b1;
    run(80);
  endtask

  initial begin
    // R1: reset state
    run(4);
    chk(ir_tx_n == 1'b1, "R1", "ir_tx_n in reset", ir_tx_n, 1);
    chk(rx_ser == 1'b1, "R1", "rx_ser in reset", rx_ser, 1);
    chk(txd == ser_in, "R1", "txd in reset", txd, ser_in);
    rst_n = 1'b1;
    run(4);

    // R6: sir off, then uart off with sir on; external pulses ignored
    tag_ir = "R6"; tag_rx = "R6"; uart_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      ser_in = (i % 37) < 20; ir_rx_n = (i % 23) > 5; step();
    end
    uart_en = 1'b0; sir_en = 1'b1; loop_test = 1'b1;
    for (int i = 0; i < 300; i++) begin
      ser_in = (i % 41) < 17; ir_rx_n = (i % 19) > 4; step();
    end
    ir_rx_n = 1'b1; ser_in = 1'b1;

    // R2/R3 normal pulses, looped back into the decoder (R8, R9)
    uart_en = 1'b1; tag_ir = "R2"; tag_rx = "R9"; run(80);
    exp_w = 3 * TICK_DIV; tag_w = "R2";
    send_bits(8'b1011_0010);
    tag_ir = "R3"; send_bits(8'hFF);

    // R4 low-power pulses at two reference rates
    exp_w = 0; lp_mode = 1'b1; run(80);
    tag_ir = "R4"; tag_w = "R4"; lp_div = 5; exp_w = 3 * 5;
    send_bits(8'b0100_1100);
    exp_w = 0; run(20); lp_div = 3; run(20); exp_w = 3 * 3;
    send_bits(8'b0001_0010);

    // R5 mode toggled in mid-bit
    exp_w = 0; tag_ir = "R5"; lp_div = 5;
    for (int i = 0; i < 700; i++) begin
      if (i % 23 == 0) lp_mode = !lp_mode;
      ser_in = (i / 64) % 3 == 1;
      step();
    end
    ser_in = 1'b1; lp_mode = 1'b0; run(80);

    // R8 external source, then loopback ignoring external input
    tag_ir = "R8"; tag_rx = "R8"; loop_test = 1'b0;
    for (int i = 0; i < 600; i++) begin ir_rx_n = (i % 100) >= 8; step(); end
    loop_test = 1'b1;
    for (int i = 0; i < 400; i++) begin ir_rx_n = (i % 90) >= 8; step(); end
    ir_rx_n = 1'b1; run(10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule